// File: doc/BRIEF.md
# Two-Slice Protected Cluster Link

This block moves a 9-bit cluster vector across a backplane that has only 7 parallel lines. The vector holds 8 physics clusters and 1 test cluster. Each transfer takes two consecutive bunch-crossing slices. The first slice carries a strobe and six cluster bits. The second slice carries the last three cluster bits and four Hamming check bits. The transmitter and the receiver sit in the same module. The transmit lines and the receive lines are separate ports, so the two ends can be placed on different boards, or the bench can drive the receive side directly.

The same link is used for two kinds of traffic.

- **Trigger traffic.** A transfer starts on an explicit send request.
- **Busy traffic.** The transmitter keeps sending while any cluster is busy and stays silent when none is.

A transfer can begin in any clock cycle, so the receiver aligns itself on the strobe. It corrects single-bit errors and flags any error it detects. The busy view on the receive side is the OR of the two most recent transfers. This way a busy cluster is not lost while a transfer is in flight.

Top module: `cluster_backplane_link`

## Requirements
- R1: When a transfer starts, the transmitter drives the first slice in the next cycle. Line 6 carries the strobe (1), and lines 5..0 carry clusters 6..1, with line 0 carrying cluster 1 (vector bit 0).
- R2: In the cycle after the first slice, the transmitter drives the second slice. Lines 2..0 carry vector bits 8..6, and lines 6..3 carry check bits c8,c4,c2,c1. The check bits are computed from the vector captured at the start:
  - c1 = d0^d1^d3^d4^d6^d8
  - c2 = d0^d2^d3^d5^d6
  - c4 = d1^d2^d3^d7^d8
  - c8 = d4^d5^d6^d7^d8
  
  After the second slice the lines return to zero unless a new transfer starts.
- R3: With busyMode low, a transfer starts on txSend. With busyMode high, a transfer starts whenever any bit of txClusters is set, and the lines stay zero while all bits are clear. A request sampled in the cycle in which the second slice is being loaded is ignored.
- R4: The receiver accepts a strobe in any cycle and treats the following cycle as the second slice. rxValid is a one-cycle pulse in the cycle after the second slice, with rxClusters holding the recovered vector.
- R5: A single flipped bit in any of the 13 protected positions (6 data lines of slice one, all 7 lines of slice two) is corrected, and rxError is high with rxValid.
- R6: An error-free transfer gives rxError low. A transfer with two flipped protected bits gives rxError high. rxError is never high without rxValid.
- R7: rxBusy is the OR of the two most recent received vectors. Two consecutive idle slices on the receive lines count as one empty transfer, so a single busy transfer keeps rxBusy set for two transfer times.
- R8: During reset, txLines, rxValid, rxError and rxBusy are zero.
- R9: A first slice without the strobe on line 6 is not received, and no rxValid follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busyMode | input | 1 | 1: send while any cluster is busy; 0: send on txSend |
| txSend | input | 1 | Transfer request in trigger mode |
| txClusters | input | 9 | Cluster vector to send (bit 8 = test cluster) |
| txLines | output | 7 | Transmit backplane lines |
| rxLines | input | 7 | Receive backplane lines |
| rxClusters | output | 9 | Last recovered and corrected cluster vector |
| rxValid | output | 1 | One-cycle pulse when rxClusters is updated |
| rxError | output | 1 | Nonzero syndrome on the transfer marked by rxValid |
| rxBusy | output | 9 | OR of the two most recent received vectors |

## Verification
The hardest cases to reach from the ports are corrupted transfers and the busy stretch across idle gaps. A plain loop from txLines back to rxLines never produces either. The bench therefore drives rxLines on its own, using slices it builds from its own check-bit equations. It flips each of the 13 protected positions in turn, then flips pairs of positions. It also times idle slices precisely so that the empty-transfer shift of rxBusy can be observed cycle by cycle. On the receive side it also places strobes at both odd and even offsets and sends back-to-back transfers with no gap between them.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int LINES        = 7;
  localparam int CLUSTERS     = 9;
  localparam int CHECKS       = 4;
  localparam int SLICE_A_DATA = LINES - 1;
  localparam int SLICE_B_DATA = CLUSTERS - SLICE_A_DATA;
  localparam int CODE_LEN     = CLUSTERS + CHECKS;

  typedef logic [CLUSTERS-1:0] clusterVec_t;
  typedef logic [LINES-1:0]    lineVec_t;
  typedef logic [CHECKS-1:0]   checkVec_t;

  typedef struct packed {
    logic txLoadA;
    logic txSendB;
    logic rxCapA;
    logic rxCapB;
    logic rxShiftIdle;
  } linkStrobes_t;

  // Check bits of a Hamming code: data sit at the non-power-of-two positions
  function automatic checkVec_t hamCheck(input clusterVec_t d);
    checkVec_t chk;
    int idx;
    chk = '0;
    idx = 0;
    for (int p = 1; p <= CODE_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < CHECKS; k++) begin
          if (((p >> k) & 1) == 1) chk[k] = chk[k] ^ d[idx];
        end
        idx++;
      end
    end
    return chk;
  endfunction

  // Flip the data bit whose code position equals the syndrome
  function automatic clusterVec_t hamFix(input clusterVec_t d, input checkVec_t syn);
    clusterVec_t r;
    int idx;
    r = d;
    idx = 0;
    for (int p = 1; p <= CODE_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (int'(syn) == p) r[idx] = ~r[idx];
        idx++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cbl_link_ctrl.sv
module cbl_link_ctrl
  import cbl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busyMode,
  input  logic         txSend,
  input  logic         txAny,
  input  logic         rxStrobe,
  output linkStrobes_t strobes
);
  logic txPhaseB;
  logic rxPhaseB;
  logic idleSeen;
  logic txReq;
  logic rxIdle;

  assign txReq  = busyMode ? txAny : txSend;
  assign rxIdle = !rxPhaseB && !rxStrobe;

  always_comb begin
    strobes             = '0;
    strobes.txLoadA     = !txPhaseB && txReq;
    strobes.txSendB     = txPhaseB;
    strobes.rxCapA      = !rxPhaseB && rxStrobe;
    strobes.rxCapB      = rxPhaseB;
    strobes.rxShiftIdle = rxIdle && idleSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhaseB <= 1'b0;
      rxPhaseB <= 1'b0;
      idleSeen <= 1'b0;
    end else begin
      txPhaseB <= strobes.txLoadA;
      rxPhaseB <= strobes.rxCapA;
      idleSeen <= rxIdle && !idleSeen;
    end
  end
endmodule

// File: rtl/cbl_link_datapath.sv
module cbl_link_datapath
  import cbl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  linkStrobes_t strobes,
  input  clusterVec_t  txClusters,
  output lineVec_t     txLines,
  output logic         txAny,
  input  lineVec_t     rxLines,
  output clusterVec_t  rxClusters,
  output logic         rxValid,
  output logic         rxError,
  output clusterVec_t  rxBusy
);
  clusterVec_t                txHold;
  logic [SLICE_A_DATA-1:0]    rxHoldA;
  clusterVec_t                rxData;
  checkVec_t                  rxSyn;
  clusterVec_t                rxFixed;
  clusterVec_t                busyLast;
  clusterVec_t                busyPrev;

  assign txAny   = |txClusters;
  assign rxData  = {rxLines[SLICE_B_DATA-1:0], rxHoldA};
  assign rxSyn   = hamCheck(rxData) ^ rxLines[LINES-1:SLICE_B_DATA];
  assign rxFixed = hamFix(rxData, rxSyn);
  assign rxBusy  = busyLast | busyPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLines <= '0;
      txHold  <= '0;
    end else if (strobes.txLoadA) begin
      txLines <= {1'b1, txClusters[SLICE_A_DATA-1:0]};
      txHold  <= txClusters;
    end else if (strobes.txSendB) begin
      txLines <= {hamCheck(txHold), txHold[CLUSTERS-1:SLICE_A_DATA]};
    end else begin
      txLines <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHoldA    <= '0;
      rxClusters <= '0;
      rxValid    <= 1'b0;
      rxError    <= 1'b0;
      busyLast   <= '0;
      busyPrev   <= '0;
    end else begin
      rxValid <= strobes.rxCapB;
      rxError <= strobes.rxCapB && (rxSyn != '0);
      if (strobes.rxCapA) rxHoldA <= rxLines[SLICE_A_DATA-1:0];
      if (strobes.rxCapB) begin
        rxClusters <= rxFixed;
        busyLast   <= rxFixed;
        busyPrev   <= busyLast;
      end else if (strobes.rxShiftIdle) begin
        busyLast <= '0;
        busyPrev <= busyLast;
      end
    end
  end
endmodule

// File: rtl/cluster_backplane_link.sv
module cluster_backplane_link
  import cbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busyMode,
  input  logic       txSend,
  input  logic [8:0] txClusters,
  output logic [6:0] txLines,
  input  logic [6:0] rxLines,
  output logic [8:0] rxClusters,
  output logic       rxValid,
  output logic       rxError,
  output logic [8:0] rxBusy
);
  linkStrobes_t strobes;
  logic         txAny;

  cbl_link_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busyMode (busyMode),
    .txSend   (txSend),
    .txAny    (txAny),
    .rxStrobe (rxLines[LINES-1]),
    .strobes  (strobes)
  );

  cbl_link_datapath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .txClusters (txClusters),
    .txLines    (txLines),
    .txAny      (txAny),
    .rxLines    (rxLines),
    .rxClusters (rxClusters),
    .rxValid    (rxValid),
    .rxError    (rxError),
    .rxBusy     (rxBusy)
  );
endmodule

// File: rtl/cbl_link_checker.sv
module cbl_link_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busyMode,
  input logic       txSend,
  input logic [8:0] txClusters,
  input logic [6:0] txLines,
  input logic [6:0] rxLines,
  input logic [8:0] rxClusters,
  input logic       rxValid,
  input logic       rxError,
  input logic [8:0] rxBusy
);
  logic txReq;
  assign txReq = busyMode ? (|txClusters) : txSend;

  p_slice_a_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!txReq) && txReq) |=> (txLines == {1'b1, $past(txClusters[5:0])}));

  p_quiet_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!txReq && $past(!txReq)) |=> (txLines == 7'd0));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(rxLines[6], 2));

  p_error_with_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxError |-> rxValid);

  p_busy_stretch_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> ((rxBusy & $past(rxClusters)) == $past(rxClusters)));
endmodule

bind cluster_backplane_link cbl_link_checker uChecker (.*);

// File: tb/tb_cluster_backplane_link.sv
module tb_cluster_backplane_link;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busyMode = 1'b0;
  logic       txSend = 1'b0;
  logic [8:0] txClusters = '0;
  logic [6:0] txLines;
  logic [6:0] rxLinesD = '0;
  logic [8:0] rxClusters;
  logic       rxValid;
  logic       rxError;
  logic [8:0] rxBusy;
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  cluster_backplane_link dut (
    .clk(clk), .rstN(rstN), .busyMode(busyMode), .txSend(txSend),
    .txClusters(txClusters), .txLines(txLines), .rxLines(rxLinesD),
    .rxClusters(rxClusters), .rxValid(rxValid), .rxError(rxError), .rxBusy(rxBusy)
  );

  function automatic logic [3:0] expChk(input logic [8:0] d);
    logic c1, c2, c4, c8;
    c1 = d[0]^d[1]^d[3]^d[4]^d[6]^d[8];
    c2 = d[0]^d[2]^d[3]^d[5]^d[6];
    c4 = d[1]^d[2]^d[3]^d[7]^d[8];
    c8 = d[4]^d[5]^d[6]^d[7]^d[8];
    return {c8, c4, c2, c1};
  endfunction

  function automatic logic [6:0] sliceA(input logic [8:0] d);
    return {1'b1, d[5:0]};
  endfunction

  function automatic logic [6:0] sliceB(input logic [8:0] d);
    return {expChk(d), d[8:6]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drives one two-slice transfer on the receive lines; returns in the rxValid cycle
  task automatic rxXfer(input logic [8:0] d, input logic [6:0] mA, input logic [6:0] mB);
    rxLinesD = sliceA(d) ^ mA;
    @(negedge clk);
    rxLinesD = sliceB(d) ^ mB;
    @(negedge clk);
    rxLinesD = '0;
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    check("R8 txLines in reset", 16'(txLines), 16'd0);
    check("R8 rxValid in reset", 16'(rxValid), 16'd0);
    check("R8 rxError in reset", 16'(rxError), 16'd0);
    check("R8 rxBusy in reset", 16'(rxBusy), 16'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tTxTrigger(input logic [8:0] d);
    busyMode = 1'b0; txClusters = d; txSend = 1'b1;
    @(negedge clk);
    check("R1 first slice", 16'(txLines), 16'(sliceA(d)));
    txSend = 1'b0; txClusters = ~d;
    @(negedge clk);
    check("R2 second slice uses captured vector", 16'(txLines), 16'(sliceB(d)));
    @(negedge clk);
    check("R2 lines return to zero", 16'(txLines), 16'd0);
    txClusters = '0;
  endtask

  task automatic tTxIgnore;
    busyMode = 1'b0; txClusters = 9'h0A5; txSend = 1'b1;
    @(negedge clk);
    check("R1 slice on held request", 16'(txLines), 16'(sliceA(9'h0A5)));
    @(negedge clk);
    check("R2 slice on held request", 16'(txLines), 16'(sliceB(9'h0A5)));
    txSend = 1'b0;
    @(negedge clk);
    check("R3 request during second slice ignored", 16'(txLines), 16'd0);
    txClusters = '0;
  endtask

  task automatic tTxBusy;
    busyMode = 1'b1; txClusters = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R3 busy mode silent when idle", 16'(txLines), 16'd0);
    end
    txClusters = 9'h181;
    @(negedge clk);
    check("R3 busy mode first slice", 16'(txLines), 16'(sliceA(9'h181)));
    @(negedge clk);
    check("R3 busy mode second slice", 16'(txLines), 16'(sliceB(9'h181)));
    @(negedge clk);
    check("R3 busy mode repeats", 16'(txLines), 16'(sliceA(9'h181)));
    txClusters = '0;
    @(negedge clk);
    check("R3 busy mode finishes pair", 16'(txLines), 16'(sliceB(9'h181)));
    @(negedge clk);
    check("R3 busy mode stops", 16'(txLines), 16'd0);
    busyMode = 1'b0;
  endtask

  task automatic tRxPhases;
    rxXfer(9'h155, '0, '0);
    check("R4 valid even phase", 16'(rxValid), 16'd1);
    check("R4 data even phase", 16'(rxClusters), 16'h155);
    check("R6 no error clean", 16'(rxError), 16'd0);
    @(negedge clk);
    check("R4 valid is one cycle", 16'(rxValid), 16'd0);
    rxXfer(9'h0AA, '0, '0);
    check("R4 valid odd phase", 16'(rxValid), 16'd1);
    check("R4 data odd phase", 16'(rxClusters), 16'h0AA);
    rxXfer(9'h1F0, '0, '0);
    check("R4 back-to-back valid", 16'(rxValid), 16'd1);
    check("R4 back-to-back data", 16'(rxClusters), 16'h1F0);
    repeat (6) @(negedge clk);
  endtask

  task automatic tRxSingle;
    for (int i = 0; i < 13; i++) begin
      logic [6:0] mA, mB;
      logic [8:0] d;
      d  = 9'(37 * (i + 3));
      mA = (i < 6) ? 7'(1 << i) : 7'd0;
      mB = (i < 6) ? 7'd0 : 7'(1 << (i - 6));
      rxXfer(d, mA, mB);
      check($sformatf("R5 corrected pos %0d", i), 16'(rxClusters), 16'(d));
      check($sformatf("R5 error flag pos %0d", i), 16'(rxError), 16'd1);
      @(negedge clk);
    end
  endtask

  task automatic tRxDouble;
    rxXfer(9'h0C3, 7'h03, '0);
    check("R6 double error flagged", 16'(rxError), 16'd1);
    @(negedge clk);
    rxXfer(9'h12D, 7'h10, 7'h04);
    check("R6 double error across slices", 16'(rxError), 16'd1);
    @(negedge clk);
    check("R6 error only with valid", 16'(rxError), 16'd0);
  endtask

  task automatic tRxNoStrobe;
    repeat (4) @(negedge clk);
    rxLinesD = sliceA(9'h03F) & 7'h3F;
    @(negedge clk);
    rxLinesD = sliceB(9'h03F);
    @(negedge clk);
    rxLinesD = '0;
    check("R9 no valid without strobe", 16'(rxValid), 16'd0);
    @(negedge clk);
    check("R9 still no valid", 16'(rxValid), 16'd0);
    repeat (6) @(negedge clk);
  endtask

  task automatic tRxBusy;
    check("R7 busy clear before test", 16'(rxBusy), 16'd0);
    rxXfer(9'h081, '0, '0);
    check("R7 busy set on transfer", 16'(rxBusy), 16'h081);
    @(negedge clk);
    @(negedge clk);
    check("R7 busy held after one empty slot", 16'(rxBusy), 16'h081);
    @(negedge clk);
    @(negedge clk);
    check("R7 busy clear after two empty slots", 16'(rxBusy), 16'd0);
    rxXfer(9'h011, '0, '0);
    rxXfer(9'h120, '0, '0);
    check("R7 busy ORs two transfers", 16'(rxBusy), 16'h131);
    rxXfer(9'h002, '0, '0);
    check("R7 oldest transfer dropped", 16'(rxBusy), 16'h122);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tTxTrigger(9'h1C7);
    tTxTrigger(9'h038);
    tTxIgnore();
    tTxBusy();
    tRxPhases();
    tRxSingle();
    tRxDouble();
    tRxNoStrobe();
    tRxBusy();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule